// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst access. A new external address is captured whenever either of two independent load strobes is asserted. The captured address is presented unchanged on the cycle after the load, and that first word is beat zero. Each later cycle with the step input asserted moves to the next beat. A cycle with no load and no step keeps the address where it is. Bursting is optional: a caller may load a fresh address on every cycle.

The two low address bits are generated internally from the captured start offset and a beat count. A select input chooses the ordering. In linear order the low bits count up from the start offset and wrap within the four-word block. In interleaved order the low bits are the start offset XOR the beat count. The upper address bits always come from the captured address and are never changed by stepping. The output is a registered-state address that feeds the memory datapath.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released with no load, `addr_out` is all zeros.
- R2: A rising clock edge with `ld_strobe_a` or `ld_strobe_b` high, alone or together, makes `addr_out` equal to `addr_in` after that edge.
- R3: With `order_linear` = 1, each step makes the two low bits of `addr_out` equal to (previous low bits + 1) mod 4. For example, a start of 2 gives 2,3,0,1.
- R4: With `order_linear` = 0, the two low bits after k steps equal the start low bits XOR (k mod 4). For example, a start of 1 gives 1,0,3,2.
- R5: The value 0 on `order_linear` (the tie-low default) selects interleaved ordering.
- R6: With no load strobe and `step_en` low, `addr_out` keeps its value.
- R7: A load strobe in the same cycle as `step_en` performs the load and does not step, so `addr_out` equals `addr_in`.
- R8: Stepping never changes `addr_out[ADDR_W-1:2]`. After four steps the address wraps back to the start word of the same block.
- R9: A load in the middle of a burst restarts at the new address with the beat count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_strobe_a | input | 1 | First load strobe; captures `addr_in` |
| ld_strobe_b | input | 1 | Second load strobe; captures `addr_in` |
| step_en | input | 1 | Advance the burst by one beat |
| order_linear | input | 1 | 1 = linear wrap order, 0 = interleaved XOR order |
| addr_in | input | ADDR_W | External address to load |
| addr_out | output | ADDR_W | Current burst word address |

## Verification
The bench targets the start offsets on which the two orderings differ. An offset of 1 tells them apart: an ordering swapped with the other would give 1,2,3,0 where 1,0,3,2 is expected. Offset 3 in linear mode crosses the wrap point, so a counter that carried into the upper bits would change the block address. The bench also applies a load together with a step; a design that let the step win would show the second word instead of the loaded one. Loads in mid-burst and on each strobe separately check that the beat count restarts and that neither strobe is ignored.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } burst_cmd_e;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    // Load has priority over stepping.
    function automatic burst_cmd_e decode_cmd(input logic ld_a,
                                              input logic ld_b,
                                              input logic step);
        burst_cmd_e c;
        if (ld_a || ld_b)
            c = CMD_LOAD;
        else if (step)
            c = CMD_STEP;
        else
            c = CMD_HOLD;
        return c;
    endfunction

endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_pkg::*;
(
    input  logic       ld_a,
    input  logic       ld_b,
    input  logic       step,
    input  logic       order_bit,
    output burst_cmd_e cmd,
    output burst_order_e order
);
    always_comb begin
        cmd   = decode_cmd(ld_a, ld_b, step);
        order = (order_bit == 1'b1) ? ORD_LINEAR : ORD_INTERLEAVE;
    end
endmodule

// File: rtl/burst_state.sv
module burst_state
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            beat      <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    base_addr <= load_addr;
                    beat      <= '0;
                end
                CMD_STEP: beat <= beat + 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] low
);
    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;
    logic [CNT_W:0]   carry;

    assign carry[0] = 1'b0;

    // Bitwise ripple adder (wraps mod 2^CNT_W) and XOR map side by side.
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        assign lin_low[i]  = start[i] ^ beat[i] ^ carry[i];
        assign carry[i+1]  = (start[i] & beat[i]) | (carry[i] & (start[i] ^ beat[i]));
        assign ilv_low[i]  = start[i] ^ beat[i];
    end

    always_comb begin
        low = (order == ORD_LINEAR) ? lin_low : ilv_low;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_strobe_a,
    input  logic              ld_strobe_b,
    input  logic              step_en,
    input  logic              order_linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UPPER_W = ADDR_W - CNT_W;

    burst_cmd_e       cmd;
    burst_order_e     order;
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  beat;
    logic [CNT_W-1:0]  low;

    burst_cmd_dec u_dec (
        .ld_a     (ld_strobe_a),
        .ld_b     (ld_strobe_b),
        .step     (step_en),
        .order_bit(order_linear),
        .cmd      (cmd),
        .order    (order)
    );

    burst_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_addr(addr_in),
        .base_addr(base_addr),
        .beat     (beat)
    );

    burst_low_map #(.CNT_W(CNT_W)) u_map (
        .start(base_addr[CNT_W-1:0]),
        .beat (beat),
        .order(order),
        .low  (low)
    );

    assign addr_out = {base_addr[ADDR_W-1 -: UPPER_W], low};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_strobe_a,
    input logic              ld_strobe_b,
    input logic              step_en,
    input logic              order_linear,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);
    logic any_load;
    assign any_load = ld_strobe_a | ld_strobe_b;

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        any_load |=> addr_out == $past(addr_in)) else $error("load"); // R2

    AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (rst)
        (any_load && step_en) |=> addr_out == $past(addr_in)) else $error("prio"); // R7

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!any_load && !step_en) |=>
            (addr_out == $past(addr_out) || order_linear != $past(order_linear)))
        else $error("hold"); // R6

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !any_load |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]))
        else $error("upper"); // R8

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!any_load && step_en && order_linear) |=>
            (!order_linear ||
             addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1)))
        else $error("linear"); // R3
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_a = 1'b0, ld_b = 1'b0, step = 1'b0, lin = 1'b0;
    logic [AW-1:0] ain = '0;
    logic [AW-1:0] aout;

    typedef struct {
        logic [AW-1:0] exp;
        string         tag;
    } item_t;

    item_t q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // model state
    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) dut_i (
        .clk(clk), .rst(rst), .ld_strobe_a(ld_a), .ld_strobe_b(ld_b),
        .step_en(step), .order_linear(lin), .addr_in(ain), .addr_out(aout)
    );

    function automatic logic [AW-1:0] model_addr(input logic l);
        logic [1:0] s, b, lo;
        s  = m_base[1:0];
        b  = 2'(m_beat);
        lo = l ? 2'(s + b) : (s ^ b);
        return {m_base[AW-1:2], lo};
    endfunction

    // driver: drive at negedge, update model, push expectation
    task automatic op(input bit a, input bit b, input bit s, input bit l,
                      input logic [AW-1:0] addr, input string tag);
        item_t it;
        @(negedge clk);
        ld_a = a; ld_b = b; step = s; lin = l; ain = addr;
        if (a || b) begin
            m_base = addr;
            m_beat = 0;
        end else if (s) begin
            m_beat = (m_beat + 1) % 4;
        end
        it.exp = model_addr(l);
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: sample 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (aout !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, aout, it.exp);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        op(0, 0, 0, 0, 20'h0, "R1 reset");
        rst = 1'b0;
        op(0, 0, 0, 0, 20'h0, "R1 after release");

        // linear from 2 via strobe a
        op(1, 0, 0, 1, 20'h12342, "R2 load a");
        op(0, 0, 1, 1, 20'h0, "R3 beat1");
        op(0, 0, 1, 1, 20'h0, "R3 beat2");
        op(0, 0, 1, 1, 20'h0, "R3 beat3");
        op(0, 0, 1, 1, 20'h0, "R8 wrap");
        op(0, 0, 0, 1, 20'hFFFFF, "R6 hold");
        op(0, 0, 0, 1, 20'h0, "R6 hold2");

        // interleaved from 1 via strobe b, default order value 0
        op(0, 1, 0, 0, 20'hABCD1, "R2 load b");
        op(0, 0, 1, 0, 20'h0, "R4 R5 beat1");
        op(0, 0, 1, 0, 20'h0, "R4 beat2");
        op(0, 0, 1, 0, 20'h0, "R4 beat3");
        op(0, 0, 1, 0, 20'h0, "R8 wrap ilv");

        // linear from 3: wraps to 0 without carry
        op(1, 1, 0, 1, 20'h0FFF3, "R2 both strobes");
        op(0, 0, 1, 1, 20'h0, "R8 no carry");
        op(0, 0, 1, 1, 20'h0, "R3 after wrap");

        // load with step in same cycle
        op(1, 0, 1, 1, 20'h55556, "R7 load wins");
        op(0, 0, 1, 1, 20'h0, "R7 next beat");

        // mid-burst reload, interleaved from 3
        op(0, 0, 1, 0, 20'h0, "R4 mid");
        op(0, 1, 0, 0, 20'h77773, "R9 reload");
        op(0, 0, 1, 0, 20'h0, "R9 beat restart");
        op(0, 0, 1, 0, 20'h0, "R4 from3");
        op(0, 0, 0, 0, 20'h0, "R6 idle");

        @(negedge clk);
        ld_a = 0; ld_b = 0; step = 0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule